// File: doc/BRIEF.md
# Reservation Station Pool with Dual Result-Bus Snooping

This block holds the waiting integer add and branch operations of a dynamically scheduled core. It has three add stations and two branch stations. Each station keeps an operation, two operand values and, for each operand, a tag. A zero tag means the operand value is present. A nonzero tag names the unit that will produce the value. The issue stage picks a free station, and it can fill two stations per cycle. Every station watches two result buses. When a bus carries the tag the station waits for, the station takes the value from that bus.

When a station's operands are complete, it competes for one of two single-cycle units: an adder shared by the add stations and a comparator shared by the branch stations. If several stations are ready, the one allocated earliest wins. The adder's result is presented one cycle later as a result-bus request, with the station's tag. A branch produces no register result. It reports a taken/not-taken outcome one cycle after it is evaluated. A station allocated after a branch that has not yet been evaluated is held back until that branch has computed its condition.

Top module: `rs_pool`

## Requirements
- R1: While reset is asserted and afterwards with nothing allocated, `res_valid_o` and `br_valid_o` stay low and every station is free.
- R2: Station tags are fixed: add stations are 1 to 3 and branch stations are 4 and 5. Tags 6 and 7 belong to external producers, and tag 0 means "value present". A result carries the tag of the station it was allocated into.
- R3: Operation codes are ADD=0, SUB=1, BEQ=2 and BNE=3. An add station allocated in cycle t with both tags zero executes in cycle t+1. Its result (a+b or a-b, modulo 2^16) appears on `res_*_o` in cycle t+2.
- R4: A waiting operand whose tag equals the tag of a valid result bus in cycle c takes that bus value. The station can execute in cycle c+1, so an add result appears in cycle c+2.
- R5: Both buses are snooped in the same cycle, so two operands of one station can be filled by the two buses in one cycle.
- R6: A broadcast in the same cycle as the allocation of a station waiting for it is captured by that station.
- R7: Two stations can be allocated in one cycle. Slot 0 counts as older than slot 1.
- R8: At most one add executes per cycle. The oldest ready add station wins, and a station that loses retries in the next cycle.
- R9: A branch station evaluates in one cycle (BEQ taken when equal, BNE taken when unequal). It reports `br_valid_o`, its tag and `br_taken_o` in the next cycle, and it never drives `res_valid_o`.
- R10: A station allocated after a branch that has not yet been evaluated does not execute before the cycle after that branch's evaluation. Stations allocated before the branch are not delayed.
- R11: An add station is freed at the end of the cycle in which its result is presented. A branch station is freed at the end of its evaluation cycle. A freed station can be allocated again in the next cycle.
- R12: A result bus whose valid is low, or whose tag does not match, leaves waiting operands unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alloc_valid_i | input | 2 | Allocation request per issue slot |
| alloc_tag_i | input | 2x3 | Target station tag per slot |
| alloc_op_i | input | 2x2 | Operation code per slot |
| alloc_vj_i | input | 2x16 | First operand value per slot |
| alloc_qj_i | input | 2x3 | First operand producer tag per slot (0 = value present) |
| alloc_vk_i | input | 2x16 | Second operand value per slot |
| alloc_qk_i | input | 2x3 | Second operand producer tag per slot (0 = value present) |
| cdb_valid_i | input | 2 | Result bus valid, one per bus |
| cdb_tag_i | input | 2x3 | Result bus producer tag |
| cdb_value_i | input | 2x16 | Result bus value |
| res_valid_o | output | 1 | Add result request valid |
| res_tag_o | output | 3 | Tag of the station producing the result |
| res_value_o | output | 16 | Add result value |
| br_valid_o | output | 1 | Branch outcome valid |
| br_tag_o | output | 3 | Tag of the resolved branch station |
| br_taken_o | output | 1 | Branch condition outcome |

## Verification
The hardest case to reach is branch hold while other ordering rules also apply. The test needs an add station that is ready but younger than a branch still waiting for an operand. It also needs a second younger add that becomes ready while the branch is still held, so that oldest-first ordering decides what happens once the hold lifts. The stimulus builds this over several cycles. It allocates a BNE waiting on an external tag together with a ready add in one cycle, allocates another ready add in the next cycle, and releases the branch operand on a bus a cycle later. It then checks that both adds stay silent until the branch outcome appears and that they then produce results in allocation order. Other directed sequences cover the remaining cases: same-cycle bus capture at allocation, filling both operands from both buses, chaining through the pool's own result looped back onto a bus, and reusing a station right after it is freed.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_BEQ = 2'd2,
    OP_BNE = 2'd3
  } rs_op_e;

  localparam int unsigned NUM_BUS   = 2;
  localparam int unsigned NUM_ISSUE = 2;
endpackage

// File: rtl/rs_opnd_snoop.sv
module rs_opnd_snoop
  import rs_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W  = 3
) (
  input  logic [TAG_W-1:0]                 q_i,
  input  logic [DATA_W-1:0]                v_i,
  input  logic [NUM_BUS-1:0]               cdb_valid_i,
  input  logic [NUM_BUS-1:0][TAG_W-1:0]    cdb_tag_i,
  input  logic [NUM_BUS-1:0][DATA_W-1:0]   cdb_value_i,
  output logic [TAG_W-1:0]                 q_o,
  output logic [DATA_W-1:0]                v_o
);
  always_comb begin
    q_o = q_i;
    v_o = v_i;
    for (int b = 0; b < NUM_BUS; b++) begin
      if (cdb_valid_i[b] && (q_i != '0) && (cdb_tag_i[b] == q_i)) begin
        q_o = '0;
        v_o = cdb_value_i[b];
      end
    end
  end
endmodule

// File: rtl/rs_oldest_pick.sv
module rs_oldest_pick #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0]        req_i,
  input  logic [N-1:0][N-1:0] older_i,
  output logic [N-1:0]        gnt_o,
  output logic                any_o
);
  // older_i[j][i] set: entry j was allocated before entry i
  always_comb begin
    gnt_o = req_i;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (req_i[j] && older_i[j][i]) gnt_o[i] = 1'b0;
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/rs_age_matrix.sv
module rs_age_matrix
  import rs_pkg::*;
#(
  parameter int unsigned N = 5
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_ISSUE-1:0][N-1:0]    alloc_hot_i,
  output logic [N-1:0][N-1:0]            older_o
);
  logic [N-1:0][N-1:0] older_q;

  // later slot writes win, so slot 0 ends up older than slot 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_q <= '0;
    end else begin
      for (int s = 0; s < NUM_ISSUE; s++) begin
        for (int a = 0; a < N; a++) begin
          if (alloc_hot_i[s][a]) begin
            for (int j = 0; j < N; j++) begin
              older_q[a][j] <= 1'b0;
              if (j != a) older_q[j][a] <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign older_o = older_q;
endmodule

// File: rtl/rs_alu.sv
module rs_alu
  import rs_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  rs_op_e              op_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  output logic [DATA_W-1:0]   out_o
);
  always_comb begin
    case (op_i)
      OP_ADD:  out_o = a_i + b_i;
      OP_SUB:  out_o = a_i - b_i;
      OP_BEQ:  out_o = DATA_W'(a_i == b_i);
      OP_BNE:  out_o = DATA_W'(a_i != b_i);
      default: out_o = '0;
    endcase
  end
endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W  = 3,
  parameter int unsigned N_ADD  = 3,
  parameter int unsigned N_BR   = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_ISSUE-1:0]                alloc_valid_i,
  input  logic [NUM_ISSUE-1:0][TAG_W-1:0]     alloc_tag_i,
  input  logic [NUM_ISSUE-1:0][1:0]           alloc_op_i,
  input  logic [NUM_ISSUE-1:0][DATA_W-1:0]    alloc_vj_i,
  input  logic [NUM_ISSUE-1:0][TAG_W-1:0]     alloc_qj_i,
  input  logic [NUM_ISSUE-1:0][DATA_W-1:0]    alloc_vk_i,
  input  logic [NUM_ISSUE-1:0][TAG_W-1:0]     alloc_qk_i,
  input  logic [NUM_BUS-1:0]                  cdb_valid_i,
  input  logic [NUM_BUS-1:0][TAG_W-1:0]       cdb_tag_i,
  input  logic [NUM_BUS-1:0][DATA_W-1:0]      cdb_value_i,
  output logic                                res_valid_o,
  output logic [TAG_W-1:0]                    res_tag_o,
  output logic [DATA_W-1:0]                   res_value_o,
  output logic                                br_valid_o,
  output logic [TAG_W-1:0]                    br_tag_o,
  output logic                                br_taken_o
);
  localparam int unsigned N_RS = N_ADD + N_BR;
  localparam logic [N_RS-1:0] ADD_MASK = N_RS'((1 << N_ADD) - 1);
  localparam logic [N_RS-1:0] BR_MASK  = ~ADD_MASK;

  // station state
  logic [N_RS-1:0]   busy_q, issued_q;
  rs_op_e            op_q  [N_RS];
  logic [DATA_W-1:0] vj_q  [N_RS];
  logic [DATA_W-1:0] vk_q  [N_RS];
  logic [TAG_W-1:0]  qj_q  [N_RS];
  logic [TAG_W-1:0]  qk_q  [N_RS];

  // allocation view
  logic [NUM_ISSUE-1:0][N_RS-1:0] alloc_hot;
  logic [N_RS-1:0]   take;
  rs_op_e            src_op [N_RS];
  logic [DATA_W-1:0] src_vj [N_RS];
  logic [DATA_W-1:0] src_vk [N_RS];
  logic [TAG_W-1:0]  src_qj [N_RS];
  logic [TAG_W-1:0]  src_qk [N_RS];
  logic [DATA_W-1:0] nxt_vj [N_RS];
  logic [DATA_W-1:0] nxt_vk [N_RS];
  logic [TAG_W-1:0]  nxt_qj [N_RS];
  logic [TAG_W-1:0]  nxt_qk [N_RS];

  logic [N_RS-1:0][N_RS-1:0] older;
  logic [N_RS-1:0] held, ready, add_gnt, br_gnt, free_now;
  logic            add_go, br_go;

  logic [DATA_W-1:0] add_a, add_b, br_a, br_b, add_out, br_out;
  rs_op_e            add_op, br_op;
  logic [TAG_W-1:0]  add_tag, br_tag;

  logic              res_valid_q, br_valid_q, br_taken_q;
  logic [TAG_W-1:0]  res_tag_q, br_tag_q;
  logic [DATA_W-1:0] res_value_q;

  always_comb begin
    for (int s = 0; s < NUM_ISSUE; s++) begin
      for (int i = 0; i < N_RS; i++) begin
        alloc_hot[s][i] = alloc_valid_i[s] && (alloc_tag_i[s] == TAG_W'(i + 1));
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_RS; i++) begin
      take[i]   = 1'b0;
      src_op[i] = op_q[i];
      src_vj[i] = vj_q[i];
      src_vk[i] = vk_q[i];
      src_qj[i] = qj_q[i];
      src_qk[i] = qk_q[i];
      for (int s = 0; s < NUM_ISSUE; s++) begin
        if (alloc_hot[s][i]) begin
          take[i]   = 1'b1;
          src_op[i] = rs_op_e'(alloc_op_i[s]);
          src_vj[i] = alloc_vj_i[s];
          src_vk[i] = alloc_vk_i[s];
          src_qj[i] = alloc_qj_i[s];
          src_qk[i] = alloc_qk_i[s];
        end
      end
    end
  end

  for (genvar i = 0; i < N_RS; i++) begin : g_snoop
    rs_opnd_snoop #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_snp_j (
      .q_i(src_qj[i]), .v_i(src_vj[i]),
      .cdb_valid_i(cdb_valid_i), .cdb_tag_i(cdb_tag_i), .cdb_value_i(cdb_value_i),
      .q_o(nxt_qj[i]), .v_o(nxt_vj[i])
    );
    rs_opnd_snoop #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_snp_k (
      .q_i(src_qk[i]), .v_i(src_vk[i]),
      .cdb_valid_i(cdb_valid_i), .cdb_tag_i(cdb_tag_i), .cdb_value_i(cdb_value_i),
      .q_o(nxt_qk[i]), .v_o(nxt_vk[i])
    );
  end

  rs_age_matrix #(.N(N_RS)) u_age (
    .clk_i(clk_i), .rst_ni(rst_ni), .alloc_hot_i(alloc_hot), .older_o(older)
  );

  // held while any older branch station is still unresolved
  always_comb begin
    for (int i = 0; i < N_RS; i++) begin
      held[i] = 1'b0;
      for (int j = 0; j < N_RS; j++) begin
        if (BR_MASK[j] && busy_q[j] && older[j][i]) held[i] = 1'b1;
      end
      ready[i] = busy_q[i] && !issued_q[i] && (qj_q[i] == '0) && (qk_q[i] == '0) && !held[i];
    end
  end

  rs_oldest_pick #(.N(N_RS)) u_add_pick (
    .req_i(ready & ADD_MASK), .older_i(older), .gnt_o(add_gnt), .any_o(add_go)
  );
  rs_oldest_pick #(.N(N_RS)) u_br_pick (
    .req_i(ready & BR_MASK), .older_i(older), .gnt_o(br_gnt), .any_o(br_go)
  );

  always_comb begin
    add_a = '0; add_b = '0; add_op = OP_ADD; add_tag = '0;
    br_a  = '0; br_b  = '0; br_op  = OP_BEQ; br_tag  = '0;
    for (int i = 0; i < N_RS; i++) begin
      if (add_gnt[i]) begin
        add_a = vj_q[i]; add_b = vk_q[i]; add_op = op_q[i]; add_tag = TAG_W'(i + 1);
      end
      if (br_gnt[i]) begin
        br_a = vj_q[i]; br_b = vk_q[i]; br_op = op_q[i]; br_tag = TAG_W'(i + 1);
      end
    end
  end

  rs_alu #(.DATA_W(DATA_W)) u_add_alu (.op_i(add_op), .a_i(add_a), .b_i(add_b), .out_o(add_out));
  rs_alu #(.DATA_W(DATA_W)) u_br_alu  (.op_i(br_op),  .a_i(br_a),  .b_i(br_b),  .out_o(br_out));

  always_comb begin
    for (int i = 0; i < N_RS; i++) begin
      free_now[i] = (res_valid_q && (res_tag_q == TAG_W'(i + 1))) || br_gnt[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= '0;
      issued_q <= '0;
      for (int i = 0; i < N_RS; i++) begin
        op_q[i] <= OP_ADD;
        vj_q[i] <= '0;
        vk_q[i] <= '0;
        qj_q[i] <= '0;
        qk_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_RS; i++) begin
        vj_q[i] <= nxt_vj[i];
        vk_q[i] <= nxt_vk[i];
        qj_q[i] <= nxt_qj[i];
        qk_q[i] <= nxt_qk[i];
        if (take[i]) begin
          busy_q[i]   <= 1'b1;
          issued_q[i] <= 1'b0;
          op_q[i]     <= src_op[i];
        end else begin
          if (free_now[i]) busy_q[i] <= 1'b0;
          if (add_gnt[i] || br_gnt[i]) issued_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_tag_q   <= '0;
      res_value_q <= '0;
      br_valid_q  <= 1'b0;
      br_tag_q    <= '0;
      br_taken_q  <= 1'b0;
    end else begin
      res_valid_q <= add_go;
      br_valid_q  <= br_go;
      if (add_go) begin
        res_tag_q   <= add_tag;
        res_value_q <= add_out;
      end
      if (br_go) begin
        br_tag_q   <= br_tag;
        br_taken_q <= (br_out != '0);
      end
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_tag_o   = res_tag_q;
  assign res_value_o = res_value_q;
  assign br_valid_o  = br_valid_q;
  assign br_tag_o    = br_tag_q;
  assign br_taken_o  = br_taken_q;
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk
  import rs_pkg::*;
#(
  parameter int unsigned TAG_W = 3,
  parameter int unsigned N_ADD = 3,
  parameter int unsigned N_BR  = 2
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [NUM_ISSUE-1:0]             alloc_valid_i,
  input logic [NUM_ISSUE-1:0][TAG_W-1:0]  alloc_tag_i,
  input logic [N_ADD+N_BR-1:0]            busy_q,
  input logic [N_ADD+N_BR-1:0]            held,
  input logic [N_ADD+N_BR-1:0]            add_gnt,
  input logic                             res_valid_o,
  input logic [TAG_W-1:0]                 res_tag_o,
  input logic                             br_valid_o,
  input logic [TAG_W-1:0]                 br_tag_o
);
  localparam int unsigned N_RS = N_ADD + N_BR;

  logic clash;
  always_comb begin
    clash = 1'b0;
    for (int s = 0; s < NUM_ISSUE; s++) begin
      for (int i = 0; i < N_RS; i++) begin
        if (alloc_valid_i[s] && (alloc_tag_i[s] == TAG_W'(i + 1)) && busy_q[i]) clash = 1'b1;
      end
    end
  end

  p_alloc_free_r11: assert property (@(posedge clk_i) disable iff (!rst_ni) !clash);

  p_res_tag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_tag_o != '0) && (res_tag_o <= TAG_W'(N_ADD)));

  p_br_tag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_valid_o |-> (br_tag_o > TAG_W'(N_ADD)) && (br_tag_o <= TAG_W'(N_RS)));

  p_res_no_repeat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && $past(res_valid_o)) |-> (res_tag_o != $past(res_tag_o)));

  p_one_add_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(add_gnt));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni) (add_gnt & held) == '0);
endmodule

bind rs_pool rs_pool_chk #(.TAG_W(TAG_W), .N_ADD(N_ADD), .N_BR(N_BR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .alloc_valid_i(alloc_valid_i), .alloc_tag_i(alloc_tag_i),
  .busy_q(busy_q), .held(held), .add_gnt(add_gnt),
  .res_valid_o(res_valid_o), .res_tag_o(res_tag_o),
  .br_valid_o(br_valid_o), .br_tag_o(br_tag_o)
);

// File: tb/rs_pool_tb_top.sv
module rs_pool_tb_top;
  import rs_pkg::*;

  localparam int DW = 16;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]         a_vld;
  logic [1:0][TW-1:0] a_tag, a_qj, a_qk;
  logic [1:0][1:0]    a_op;
  logic [1:0][DW-1:0] a_vj, a_vk;
  logic [1:0]         b_vld;
  logic [1:0][TW-1:0] b_tag;
  logic [1:0][DW-1:0] b_val;
  logic [1:0]         cdb_vld;
  logic [1:0][TW-1:0] cdb_tag;
  logic [1:0][DW-1:0] cdb_val;
  logic               res_valid, br_valid, br_taken;
  logic [TW-1:0]      res_tag, br_tag;
  logic [DW-1:0]      res_value;

  // bus 0 carries the pool's own result, bus 1 stands for other producers
  assign cdb_vld[0] = res_valid | b_vld[0];
  assign cdb_tag[0] = res_valid ? res_tag : b_tag[0];
  assign cdb_val[0] = res_valid ? res_value : b_val[0];
  assign cdb_vld[1] = b_vld[1];
  assign cdb_tag[1] = b_tag[1];
  assign cdb_val[1] = b_val[1];

  rs_pool dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(a_vld), .alloc_tag_i(a_tag), .alloc_op_i(a_op),
    .alloc_vj_i(a_vj), .alloc_qj_i(a_qj), .alloc_vk_i(a_vk), .alloc_qk_i(a_qk),
    .cdb_valid_i(cdb_vld), .cdb_tag_i(cdb_tag), .cdb_value_i(cdb_val),
    .res_valid_o(res_valid), .res_tag_o(res_tag), .res_value_o(res_value),
    .br_valid_o(br_valid), .br_tag_o(br_tag), .br_taken_o(br_taken)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic idle();
    a_vld = '0; a_tag = '0; a_op = '0; a_vj = '0; a_vk = '0; a_qj = '0; a_qk = '0;
    b_vld = '0; b_tag = '0; b_val = '0;
  endtask

  task automatic put(input int s, input int tag, input rs_op_e op,
                     input int vj, input int qj, input int vk, input int qk);
    a_vld[s] = 1'b1; a_tag[s] = TW'(tag); a_op[s] = op;
    a_vj[s] = DW'(vj); a_qj[s] = TW'(qj); a_vk[s] = DW'(vk); a_qk[s] = TW'(qk);
  endtask

  task automatic bus(input int b, input int tag, input int val);
    b_vld[b] = 1'b1; b_tag[b] = TW'(tag); b_val[b] = DW'(val);
  endtask

  task automatic chk_res(input string r, input bit ev, input int et, input int evl);
    n_chk++;
    if (res_valid !== ev || (ev && (res_tag !== TW'(et) || res_value !== DW'(evl)))) begin
      n_bad++;
      $display("FAIL %s: result valid=%0b tag=%0d value=%0d, expected valid=%0b tag=%0d value=%0d",
               r, res_valid, res_tag, res_value, ev, et, evl);
    end
  endtask

  task automatic chk_br(input string r, input bit ev, input int et, input bit etk);
    n_chk++;
    if (br_valid !== ev || (ev && (br_tag !== TW'(et) || br_taken !== etk))) begin
      n_bad++;
      $display("FAIL %s: branch valid=%0b tag=%0d taken=%0b, expected valid=%0b tag=%0d taken=%0b",
               r, br_valid, br_tag, br_taken, ev, et, etk);
    end
  endtask

  task automatic gap();
    idle();
    repeat (3) nxt();
  endtask

  // R1: quiet outputs in and after reset
  task automatic t_reset();
    idle();
    rst_n = 1'b0;
    repeat (3) nxt();
    chk_res("R1", 0, 0, 0);
    chk_br("R1", 0, 0, 0);
    rst_n = 1'b1;
    repeat (3) nxt();
    chk_res("R1", 0, 0, 0);
    chk_br("R1", 0, 0, 0);
  endtask

  // R2 R3 R7 R8: two ready adds in one cycle
  task automatic t_ready_pair();
    nxt(); put(0, 2, OP_ADD, 7, 0, 5, 0); put(1, 3, OP_SUB, 20, 0, 6, 0);
    nxt(); idle(); chk_res("R3", 0, 0, 0);
    nxt(); chk_res("R3", 1, 2, 12);
    nxt(); chk_res("R8", 1, 3, 14);
    nxt(); chk_res("R7", 0, 0, 0);
    gap();
  endtask

  // R4 R12: mismatched and invalid buses ignored, matching bus captured
  task automatic t_snoop_filter();
    nxt(); put(0, 1, OP_ADD, 0, 6, 3, 0);
    nxt(); idle(); bus(1, 7, 99);
    nxt(); idle(); b_tag[1] = TW'(6); b_val[1] = DW'(55);
    chk_res("R12", 0, 0, 0);
    nxt(); idle(); bus(1, 6, 40); chk_res("R12", 0, 0, 0);
    nxt(); idle(); chk_res("R4", 0, 0, 0);
    nxt(); chk_res("R4", 1, 1, 43);
    gap();
  endtask

  // R6: broadcast in the allocation cycle
  task automatic t_alloc_bypass();
    nxt(); put(0, 1, OP_ADD, 0, 6, 1, 0); bus(1, 6, 10);
    nxt(); idle();
    nxt(); chk_res("R6", 1, 1, 11);
    gap();
  endtask

  // R5: both buses fill both operands in one cycle
  task automatic t_two_bus();
    nxt(); put(0, 2, OP_ADD, 0, 6, 0, 7);
    nxt(); idle(); bus(0, 6, 100); bus(1, 7, 23);
    nxt(); idle(); chk_res("R5", 0, 0, 0);
    nxt(); chk_res("R5", 1, 2, 123);
    gap();
  endtask

  // R4: dependency through the pool's own result on bus 0
  task automatic t_chain();
    nxt(); put(0, 1, OP_ADD, 1, 0, 2, 0); put(1, 2, OP_ADD, 0, 1, 10, 0);
    nxt(); idle();
    nxt(); chk_res("R4", 1, 1, 3);
    nxt(); chk_res("R4", 0, 0, 0);
    nxt(); chk_res("R4", 1, 2, 13);
    gap();
  endtask

  // R9 R10 R8: younger adds held until the branch evaluates
  task automatic t_branch_hold();
    nxt(); put(0, 4, OP_BNE, 0, 6, 10, 0); put(1, 1, OP_ADD, 2, 0, 3, 0);
    nxt(); idle(); put(0, 2, OP_ADD, 1, 0, 1, 0);
    chk_res("R10", 0, 0, 0); chk_br("R9", 0, 0, 0);
    nxt(); idle(); bus(1, 6, 7); chk_res("R10", 0, 0, 0);
    nxt(); idle(); chk_res("R10", 0, 0, 0); chk_br("R9", 0, 0, 0);
    nxt(); chk_br("R9", 1, 4, 1); chk_res("R10", 0, 0, 0);
    nxt(); chk_res("R10", 1, 1, 5); chk_br("R9", 0, 0, 0);
    nxt(); chk_res("R8", 1, 2, 2);
    gap();
  endtask

  // R10: an add older than the branch is not delayed
  task automatic t_older_free();
    nxt(); put(0, 3, OP_ADD, 4, 0, 4, 0); put(1, 5, OP_BEQ, 0, 7, 9, 0);
    nxt(); idle(); bus(1, 7, 9); chk_res("R10", 0, 0, 0);
    nxt(); idle(); chk_res("R10", 1, 3, 8); chk_br("R9", 0, 0, 0);
    nxt(); chk_br("R9", 1, 5, 1); chk_res("R9", 0, 0, 0);
    gap();
  endtask

  // R9 R11: BEQ not taken, branch station reused
  task automatic t_beq_not_taken();
    nxt(); put(0, 4, OP_BEQ, 3, 0, 4, 0);
    nxt(); idle(); chk_br("R9", 0, 0, 0);
    nxt(); chk_br("R9", 1, 4, 0); chk_res("R9", 0, 0, 0);
    nxt(); put(0, 4, OP_BNE, 5, 0, 5, 0);
    nxt(); idle();
    nxt(); chk_br("R11", 1, 4, 0);
    gap();
  endtask

  // R11: add station reallocated in the cycle after its result
  task automatic t_reuse();
    nxt(); put(0, 2, OP_ADD, 1, 0, 2, 0);
    nxt(); idle();
    nxt(); chk_res("R11", 1, 2, 3);
    nxt(); put(0, 2, OP_ADD, 10, 0, 20, 0); chk_res("R11", 0, 0, 0);
    nxt(); idle(); chk_res("R11", 0, 0, 0);
    nxt(); chk_res("R11", 1, 2, 30);
    gap();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: cycles=20000, expected completion earlier");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    t_reset();
    t_ready_pair();
    t_snoop_filter();
    t_alloc_bypass();
    t_two_bus();
    t_chain();
    t_branch_hold();
    t_older_free();
    t_beq_not_taken();
    t_reuse();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule